// File: doc/BRIEF.md
# Journaled Nonvolatile Write Sequencer

This block stands between a host and a byte-wide nonvolatile memory port. It makes sure a write cut short by a power loss can be completed later. The host selects one of two modes for each write.

- In the plain mode the payload goes straight to its destination.
- In the protected mode the block works like a journal. It first copies the length, the destination address and the payload into a reserved journal area. It then sets a valid marker and writes the destination. Last, it clears the marker.

A reset stands for power-up. After each reset the block reads the marker. If the marker is set, it replays the journaled copy before it accepts host work. While any of this is running, the busy output is high. The host polls busy the way it would poll for a bus acknowledge. The memory port is a request/done handshake, and the physical write time is modelled by the done input.

Top module: `atw_seq`

## Requirements
- R1: After reset, busy is high and the block reads address JBASE (default 0xE0). If that byte is not the marker value 0xA5, the block returns to idle without any memory write.
- R2: A plain write (req_tear=0) of length 1 to 16 writes byte i of req_data (bits 8i+7:8i) to address req_addr+i, in increasing i. It makes no other memory access.
- R3: A protected write (req_tear=1) of length n from 1 to 8 writes these bytes, in this order:
  - n to JBASE+1;
  - the destination address to JBASE+2;
  - byte i to JBASE+3+i;
  - 0xA5 to JBASE;
  - byte i to req_addr+i;
  - 0x00 to JBASE.
- R4: A request of length 0, of length above 16, or protected with length above 8 is refused. req_reject pulses for one cycle after the accepting edge, busy stays low, and no memory access follows.
- R5: busy is high in every non-idle state. A request raised while busy is ignored.
- R6: If the marker reads 0xA5 at power-up, the block reads the length, address and payload back from the journal. It then writes the payload to the destination and writes 0x00 to JBASE.
- R7: If the marker is set but the journaled length is 0 or above 8, the block only writes 0x00 to JBASE.
- R8: Once mem_req rises, mem_addr, mem_we and mem_wdata hold until mem_done. Read data is taken in the mem_done cycle.
- R9: Destination addresses wrap modulo 2^ADDR_W (8-bit addresses by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| req_valid | input | 1 | Host write request strobe, sampled when idle |
| req_addr | input | ADDR_W | Destination start address |
| req_len | input | LEN_W | Payload length in bytes |
| req_tear | input | 1 | Request the journaled write mode |
| req_data | input | 8*PAGE_BYTES | Payload, byte i in bits 8i+7:8i |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| busy | output | 1 | High while a sequence or recovery runs |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_done |
| mem_done | input | 1 | One-cycle completion of the current operation |

## Verification
The reject pulse and the rise of busy are due one cycle after the edge that samples req_valid. Inputs change on falling edges, so the bench reads both on the next falling edge. Each memory operation ends LAT cycles after it is presented, and the next operation appears on the edge that sees mem_done. The bench therefore does not predict the exact cycle in which a sequence ends. It polls busy on falling edges with a bound, then compares the full write trace and the memory contents against lists built from the requirements. For the power-cut cases, reset is asserted as soon as the trace reaches a chosen write count. The memory contents after the replay then show whether recovery worked.

// File: rtl/atw_pkg.sv
package atw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RECOVER,
    ST_WRITE_BUF,
    ST_SET_VALID,
    ST_WRITE_DEST,
    ST_CLEAR_VALID
  } atw_state_t;

  localparam logic [7:0] MARK_SET = 8'hA5;
  localparam logic [7:0] MARK_CLR = 8'h00;
endpackage

// File: rtl/atw_payload.sv
module atw_payload #(
  parameter int BYTES = 16,
  parameter int LEN_W = 5
) (
  input  logic               clk,
  input  logic               load,
  input  logic [BYTES*8-1:0] load_data,
  input  logic               wr_en,
  input  logic [LEN_W-1:0]   wr_idx,
  input  logic [7:0]         wr_byte,
  input  logic [LEN_W-1:0]   rd_idx,
  output logic [7:0]         rd_byte
);
  logic [7:0] slot [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load) begin
        slot[g] <= load_data[g*8 +: 8];
      end else if (wr_en && wr_idx == LEN_W'(g)) begin
        slot[g] <= wr_byte;
      end
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < BYTES; i++) begin
      if (rd_idx == LEN_W'(i)) rd_byte = slot[i];
    end
  end
endmodule

// File: rtl/atw_ctrl.sv
module atw_ctrl
  import atw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int TEAR_BYTES = 8,
  parameter int LEN_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_tear,
  input  logic              mem_done,
  input  logic [7:0]        mem_rdata,
  output atw_state_t        state,
  output logic [LEN_W-1:0]  idx,
  output logic [LEN_W-1:0]  len_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              busy,
  output logic              req_reject,
  output logic              pl_load,
  output logic              pl_wr
);
  logic tear_q;
  logic bad_req;
  logic bad_jlen;

  assign bad_req = (req_len == '0) || (req_len > LEN_W'(PAGE_BYTES)) ||
                   (req_tear && (req_len > LEN_W'(TEAR_BYTES)));
  assign bad_jlen = (mem_rdata == 8'h00) || (mem_rdata > 8'(TEAR_BYTES));
  assign busy     = (state != ST_IDLE);
  assign pl_load  = (state == ST_IDLE) && req_valid && !bad_req;
  assign pl_wr    = (state == ST_RECOVER) && mem_done && (idx >= LEN_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CHECK;
      idx        <= '0;
      len_q      <= '0;
      addr_q     <= '0;
      tear_q     <= 1'b0;
      req_reject <= 1'b0;
    end else begin
      req_reject <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (bad_req) begin
              req_reject <= 1'b1;
            end else begin
              len_q  <= req_len;
              addr_q <= req_addr;
              tear_q <= req_tear;
              idx    <= '0;
              state  <= req_tear ? ST_WRITE_BUF : ST_WRITE_DEST;
            end
          end
        end
        ST_CHECK: begin
          if (mem_done) begin
            idx   <= '0;
            state <= (mem_rdata == MARK_SET) ? ST_RECOVER : ST_IDLE;
          end
        end
        ST_RECOVER: begin
          if (mem_done) begin
            if (idx == '0) begin
              if (bad_jlen) begin
                state <= ST_CLEAR_VALID;
              end else begin
                len_q <= mem_rdata[LEN_W-1:0];
                idx   <= LEN_W'(1);
              end
            end else if (idx == LEN_W'(1)) begin
              addr_q <= mem_rdata[ADDR_W-1:0];
              idx    <= LEN_W'(2);
            end else if (idx == len_q + LEN_W'(1)) begin
              idx    <= '0;
              tear_q <= 1'b1;
              state  <= ST_WRITE_DEST;
            end else begin
              idx <= idx + LEN_W'(1);
            end
          end
        end
        ST_WRITE_BUF: begin
          if (mem_done) begin
            if (idx == len_q + LEN_W'(1)) begin
              idx   <= '0;
              state <= ST_SET_VALID;
            end else begin
              idx <= idx + LEN_W'(1);
            end
          end
        end
        ST_SET_VALID: begin
          if (mem_done) begin
            idx   <= '0;
            state <= ST_WRITE_DEST;
          end
        end
        ST_WRITE_DEST: begin
          if (mem_done) begin
            if (idx == len_q - LEN_W'(1)) begin
              idx   <= '0;
              state <= tear_q ? ST_CLEAR_VALID : ST_IDLE;
            end else begin
              idx <= idx + LEN_W'(1);
            end
          end
        end
        ST_CLEAR_VALID: begin
          if (mem_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_reject |-> !busy);

  // R3
  tear_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE_BUF) |-> (len_q != '0 && len_q <= LEN_W'(TEAR_BYTES)));

  // R3
  marker_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SET_VALID && $past(state) != ST_SET_VALID) |->
      ($past(state) == ST_WRITE_BUF));

  // R2
  plain_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLEAR_VALID && $past(state) == ST_WRITE_DEST) |-> tear_q);
endmodule

// File: rtl/atw_port.sv
module atw_port
  import atw_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter int                LEN_W  = 5,
  parameter logic [ADDR_W-1:0] JBASE  = 8'hE0
) (
  input  logic              clk,
  input  logic              rst,
  input  atw_state_t        state,
  input  logic [LEN_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [7:0]        pl_byte,
  input  logic              mem_done,
  output logic [LEN_W-1:0]  pl_rd_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  logic [ADDR_W-1:0] jslot;

  assign jslot = JBASE + ADDR_W'(idx) + ADDR_W'(1);

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = JBASE;
    mem_wdata = MARK_CLR;
    pl_rd_idx = idx;
    case (state)
      ST_IDLE: mem_req = 1'b0;
      ST_CHECK: begin
        mem_addr = JBASE;
      end
      ST_RECOVER: begin
        mem_addr = jslot;
      end
      ST_WRITE_BUF: begin
        mem_we    = 1'b1;
        mem_addr  = jslot;
        pl_rd_idx = idx - LEN_W'(2);
        if (idx == '0)             mem_wdata = 8'(len_q);
        else if (idx == LEN_W'(1)) mem_wdata = 8'(addr_q);
        else                       mem_wdata = pl_byte;
      end
      ST_SET_VALID: begin
        mem_we    = 1'b1;
        mem_wdata = MARK_SET;
      end
      ST_WRITE_DEST: begin
        mem_we    = 1'b1;
        mem_addr  = addr_q + ADDR_W'(idx);
        mem_wdata = pl_byte;
      end
      ST_CLEAR_VALID: begin
        mem_we    = 1'b1;
        mem_wdata = MARK_CLR;
      end
      default: mem_req = 1'b0;
    endcase
  end

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_done) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: rtl/atw_seq.sv
module atw_seq
  import atw_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                PAGE_BYTES = 16,
  parameter int                TEAR_BYTES = 8,
  parameter logic [ADDR_W-1:0] JBASE      = 8'hE0,
  localparam int               LEN_W      = $clog2(PAGE_BYTES + 2),
  localparam int               DATA_BITS  = PAGE_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 req_tear,
  input  logic [DATA_BITS-1:0] req_data,
  output logic                 req_reject,
  output logic                 busy,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [7:0]           mem_wdata,
  input  logic [7:0]           mem_rdata,
  input  logic                 mem_done
);
  atw_state_t        state;
  logic [LEN_W-1:0]  idx;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pl_load;
  logic              pl_wr;
  logic [LEN_W-1:0]  pl_rd_idx;
  logic [7:0]        pl_byte;

  atw_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
    .TEAR_BYTES(TEAR_BYTES), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_tear(req_tear), .mem_done(mem_done),
    .mem_rdata(mem_rdata), .state(state), .idx(idx), .len_q(len_q),
    .addr_q(addr_q), .busy(busy), .req_reject(req_reject),
    .pl_load(pl_load), .pl_wr(pl_wr)
  );

  atw_payload #(.BYTES(PAGE_BYTES), .LEN_W(LEN_W)) i_payload (
    .clk(clk), .load(pl_load), .load_data(req_data), .wr_en(pl_wr),
    .wr_idx(idx - LEN_W'(2)), .wr_byte(mem_rdata), .rd_idx(pl_rd_idx),
    .rd_byte(pl_byte)
  );

  atw_port #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .JBASE(JBASE)) i_port (
    .clk(clk), .rst(rst), .state(state), .idx(idx), .len_q(len_q),
    .addr_q(addr_q), .pl_byte(pl_byte), .mem_done(mem_done),
    .pl_rd_idx(pl_rd_idx), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/test_atw_seq.sv
module test_atw_seq;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [7:0]   req_addr = '0;
  logic [4:0]   req_len = '0;
  logic         req_tear = 1'b0;
  logic [127:0] req_data = '0;
  logic         req_reject, busy, mem_req, mem_we;
  logic [7:0]   mem_addr, mem_wdata;
  logic [7:0]   mem_rdata = '0;
  logic         mem_done = 1'b0;

  always #10 clk = ~clk;

  atw_seq i_atw_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_tear(req_tear), .req_data(req_data),
    .req_reject(req_reject), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_done(mem_done)
  );

  // memory model
  logic [7:0] mem [256];
  logic [7:0] la [1024];
  logic [7:0] ld [1024];
  int         wn = 0, rn = 0, lat_cnt = 0;
  logic       wipe = 1'b0, poke = 1'b0;
  logic [7:0] pk_a = '0, pk_d = '0;

  always @(posedge clk) begin
    if (wipe) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (poke) begin
      mem[pk_a] <= pk_d;
    end
    if (rst) begin
      lat_cnt  <= 0;
      mem_done <= 1'b0;
    end else if (mem_done) begin
      mem_done <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == LAT - 1) begin
        lat_cnt  <= 0;
        mem_done <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          la[wn % 1024] <= mem_addr;
          ld[wn % 1024] <= mem_wdata;
          wn <= wn + 1;
        end else begin
          mem_rdata <= mem[mem_addr];
          rn <= rn + 1;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // handshake monitor (R8)
  logic       pv_req = 1'b0, pv_done = 1'b0, pv_we = 1'b0;
  logic [7:0] pv_addr = '0, pv_wd = '0;
  int         hs_err = 0;
  always @(posedge clk) begin
    if (!rst && pv_req && !pv_done &&
        (!mem_req || mem_addr != pv_addr || mem_we != pv_we || (pv_we && mem_wdata != pv_wd)))
      hs_err <= hs_err + 1;
    pv_req <= mem_req && !rst; pv_done <= mem_done;
    pv_addr <= mem_addr; pv_we <= mem_we; pv_wd <= mem_wdata;
  end

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
  end

  logic [7:0] ea [64];
  logic [7:0] ed [64];
  int         en;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'(s * 37 + i * 11 + 5);
  endfunction

  task automatic exp_add(input logic [7:0] a, input logic [7:0] d);
    ea[en] = a; ed[en] = d; en++;
  endtask

  task automatic build_exp(input logic [7:0] a, input int n, input bit tear, input int s);
    en = 0;
    if (tear) begin
      exp_add(8'hE1, 8'(n));
      exp_add(8'hE2, a);
      for (int i = 0; i < n; i++) exp_add(8'(8'hE3 + i), pat(s, i));
      exp_add(8'hE0, 8'hA5);
    end
    for (int i = 0; i < n; i++) exp_add(8'(a + i), pat(s, i));
    if (tear) exp_add(8'hE0, 8'h00);
  endtask

  task automatic chk_trace(input int base, input string tag);
    int bad = 0;
    chk(wn - base == en, tag, wn - base, en);
    for (int k = 0; k < en && k < wn - base; k++)
      if (la[(base + k) % 1024] != ea[k] || ld[(base + k) % 1024] != ed[k]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    @(negedge clk);
    while (busy && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(!busy, tag, busy, 0);
  endtask

  task automatic send(input logic [7:0] a, input int n, input bit tear, input int s);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 5'(n); req_tear = tear;
    for (int i = 0; i < 16; i++) req_data[8*i +: 8] = pat(s, i);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic poke_byte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    poke = 1'b1; pk_a = a; pk_d = d;
    @(negedge clk);
    poke = 1'b0;
  endtask

  task automatic pulse_rst();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk_mem(input logic [7:0] a, input int n, input int s, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[8'(a + i)] != pat(s, i)) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    int base, rb;
    wipe = 1'b1;
    repeat (3) @(negedge clk);
    wipe = 1'b0;
    rst = 1'b0;
    // R1: busy right after reset, one marker read, no writes
    chk(busy == 1'b1, "R1 busy after reset", busy, 1);
    wait_idle("R1 idle");
    chk(rn == 1 && wn == 0, "R1 marker read only", rn * 100 + wn, 100);

    // R2: plain write sweep
    for (int n = 1; n <= 16; n++) begin
      base = wn; rb = rn;
      send(8'(n * 9), n, 1'b0, n);
      chk(busy == 1'b1 && req_reject == 1'b0, "R5 busy on plain", busy, 1);
      wait_idle("R2 plain idle");
      build_exp(8'(n * 9), n, 1'b0, n);
      chk_trace(base, "R2 plain trace");
      chk(rn == rb, "R2 no reads", rn - rb, 0);
      chk_mem(8'(n * 9), n, n, "R2 plain memory");
    end

    // R3: protected write sweep
    for (int n = 1; n <= 8; n++) begin
      base = wn;
      send(8'(8'h80 + n * 4), n, 1'b1, n + 40);
      wait_idle("R3 tear idle");
      build_exp(8'(8'h80 + n * 4), n, 1'b1, n + 40);
      chk_trace(base, "R3 tear trace");
      chk_mem(8'(8'h80 + n * 4), n, n + 40, "R3 tear memory");
      chk(mem[8'hE0] == 8'h00, "R3 marker cleared", mem[8'hE0], 0);
    end

    // R9: wrap
    base = wn;
    send(8'hFA, 10, 1'b0, 77);
    wait_idle("R9 idle");
    build_exp(8'hFA, 10, 1'b0, 77);
    chk_trace(base, "R9 wrap trace");
    chk_mem(8'hFA, 10, 77, "R9 wrap memory");

    // R4: rejects
    for (int k = 0; k < 11; k++) begin
      int n;
      bit t;
      n = (k == 0) ? 0 : (k == 1) ? 17 : (k == 2) ? 31 : k + 6;
      t = (k >= 3);
      base = wn; rb = rn;
      send(8'h20, n, t, 5);
      chk(req_reject == 1'b1 && busy == 1'b0, "R4 reject pulse", req_reject, 1);
      @(negedge clk);
      chk(req_reject == 1'b0, "R4 pulse single", req_reject, 0);
      repeat (10) @(negedge clk);
      chk(wn == base && rn == rb && !busy, "R4 no access", wn - base, 0);
    end

    // R5: request while busy ignored
    base = wn;
    send(8'h30, 16, 1'b0, 9);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R5 busy mid write", busy, 1);
    req_valid = 1'b1; req_addr = 8'h60; req_len = 5'd2; req_tear = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle("R5 idle");
    build_exp(8'h30, 16, 1'b0, 9);
    chk_trace(base, "R5 ignored request");

    // R6 + R9: recovery of a journal wrapping the destination
    poke_byte(8'hE1, 8'd3);
    poke_byte(8'hE2, 8'hFE);
    for (int i = 0; i < 3; i++) poke_byte(8'(8'hE3 + i), pat(60, i));
    poke_byte(8'hE0, 8'hA5);
    base = wn; rb = rn;
    pulse_rst();
    wait_idle("R6 idle");
    en = 0;
    for (int i = 0; i < 3; i++) exp_add(8'(8'hFE + i), pat(60, i));
    exp_add(8'hE0, 8'h00);
    chk_trace(base, "R6 recovery trace");
    chk(rn - rb == 6, "R6 journal reads", rn - rb, 6);
    chk_mem(8'hFE, 3, 60, "R6 recovered memory");

    // R7: corrupt journal lengths
    for (int k = 0; k < 2; k++) begin
      poke_byte(8'hE1, (k == 0) ? 8'd0 : 8'd9);
      poke_byte(8'hE0, 8'hA5);
      base = wn;
      pulse_rst();
      wait_idle("R7 idle");
      en = 0;
      exp_add(8'hE0, 8'h00);
      chk_trace(base, "R7 bad length clear only");
    end

    // R6: power cut during the destination copy
    for (int i = 0; i < 8; i++) poke_byte(8'(8'h40 + i), 8'hCC);
    base = wn;
    send(8'h40, 8, 1'b1, 21);
    while (wn - base < 14) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(mem[8'h43] == 8'hCC, "R6 cut left partial copy", mem[8'h43], 8'hCC);
    wait_idle("R6 cut idle");
    chk_mem(8'h40, 8, 21, "R6 replay after cut");
    chk(mem[8'hE0] == 8'h00, "R6 marker cleared", mem[8'hE0], 0);

    // R1: power cut while journaling, marker never set
    for (int i = 0; i < 4; i++) poke_byte(8'(8'h50 + i), 8'h33);
    base = wn;
    send(8'h50, 4, 1'b1, 22);
    while (wn - base < 3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    base = wn;
    wait_idle("R1 cut idle");
    chk(wn == base, "R1 no replay without marker", wn - base, 0);
    chk(mem[8'h50] == 8'h33, "R1 destination untouched", mem[8'h50], 8'h33);

    chk(hs_err == 0, "R8 handshake held", hs_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule